// File: doc/BRIEF.md
# Dual-Plane Framebuffer Scanout

This block walks a raster in row-major order and turns two byte-wide video memory planes into 24-bit RGB pixels. Each byte address holds two horizontally adjacent pixels. A pixel's 8-bit colour index takes one nibble from each plane. That index selects an entry in an internal 256-entry palette of 15-bit colour words. The default geometry shows 384 by 288 pixels inside a 512 by 512 raster.

The block issues one synchronous read per pixel pair, and the same address goes to both planes. The upper nibbles form the left pixel. The lower nibbles are held back for the right pixel. A byte-wide write port fills the palette through a window of plane A's address space. RGB leaves the block together with a delayed copy of the raster position and a valid strobe, so downstream sync logic can align to it. Fetches stop and the output is black outside the visible window.

Top module: `dual_plane_scanout`

## Requirements
- R1: The raster counts columns 0..H_TOTAL-1 within lines 0..V_TOTAL-1, row-major. `out_x`/`out_y` give the position of the pixel on `rgb`, and `out_valid` is high exactly when `out_x < H_VIS` and `out_y < V_VIS`.
- R2: The output trails the fetch by two clock edges. After reset is released, the first edge leaves `out_valid` low and the second shows pixel (0,0) with `out_valid` high.
- R3: A read (`fb_rd` high) is issued only for visible positions with an even column. Its address is line*(H_VIS/2) + column/2. No read is issued during blanking or reset.
- R4: Plane data is taken one cycle after `fb_rd`. The left (even) pixel's index is {B[7:4], A[7:4]}, with the plane B nibble as the upper half.
- R5: The right (odd) pixel's index is {B[3:0], A[3:0]} from the same byte pair. Plane inputs in cycles that follow no read have no effect on any pixel.
- R6: A palette write to a byte address from 0xFE00 through 0xFFDF updates entry address[8:1]. An even address writes word bits 15:8 and an odd address writes bits 7:0.
- R7: Palette writes to addresses outside that window leave every entry unchanged.
- R8: For a visible pixel, `rgb[23:16]` = word[14:10]<<3, `rgb[15:8]` = word[9:5]<<3 and `rgb[7:0]` = word[4:0]<<3. Word bit 15 is ignored.
- R9: `rgb` is zero whenever `out_valid` is low. While in reset, `out_valid`, `rgb`, `fb_rd`, `out_x` and `out_y` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb_rd | output | 1 | Read strobe to both planes |
| fb_addr | output | AW | Byte address shared by both planes |
| plane_a_q | input | 8 | Plane A read data, one cycle after `fb_rd` |
| plane_b_q | input | 8 | Plane B read data, one cycle after `fb_rd` |
| pal_we | input | 1 | Palette byte write enable |
| pal_addr | input | AW | Palette write byte address (plane A space) |
| pal_wdata | input | 8 | Palette write byte |
| out_valid | output | 1 | Visible pixel on `rgb` |
| out_x | output | clog2(H_TOTAL) | Column of the pixel on `rgb` |
| out_y | output | clog2(V_TOTAL) | Line of the pixel on `rgb` |
| rgb | output | 24 | Pixel colour, red in the top byte |

## Verification
The assertions assume that the plane memories return data exactly one cycle after a read. They also assume that horizontal blanking lasts at least two cycles, so consecutive fetches two cycles apart always fall on the same line or on adjacent bytes. The bench uses a synchronous memory model that meets this and drives changing junk on the plane inputs in every cycle without a read. It uses a reduced raster with eight blanking columns. Palette writes and plane updates happen between frames, and a whole frame is skipped before any frame is compared, so no comparison sees a half-updated image.

// File: rtl/dual_plane_scanout.sv
module dual_plane_scanout #(
  parameter int H_VIS   = 384,
  parameter int V_VIS   = 288,
  parameter int H_TOTAL = 512,
  parameter int V_TOTAL = 512,
  parameter int AW      = 16,
  parameter logic [AW-1:0] PAL_FIRST = 16'hFE00,
  parameter logic [AW-1:0] PAL_LAST  = 16'hFFDF,
  localparam int XW = $clog2(H_TOTAL),
  localparam int YW = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          fb_rd,
  output logic [AW-1:0] fb_addr,
  input  logic [7:0]    plane_a_q,
  input  logic [7:0]    plane_b_q,
  input  logic          pal_we,
  input  logic [AW-1:0] pal_addr,
  input  logic [7:0]    pal_wdata,
  output logic          out_valid,
  output logic [XW-1:0] out_x,
  output logic [YW-1:0] out_y,
  output logic [23:0]   rgb
);

  localparam int LINE_BYTES = H_VIS / 2;

  logic [XW-1:0] hcnt;
  logic [YW-1:0] vcnt;
  logic          h_end, v_end, vis0;

  assign h_end = hcnt == XW'(H_TOTAL - 1);
  assign v_end = vcnt == YW'(V_TOTAL - 1);
  assign vis0  = (hcnt < XW'(H_VIS)) && (vcnt < YW'(V_VIS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else begin
      hcnt <= h_end ? '0 : hcnt + 1'b1;
      if (h_end) vcnt <= v_end ? '0 : vcnt + 1'b1;
    end
  end

  assign fb_rd   = rst_n && vis0 && !hcnt[0];
  assign fb_addr = AW'(vcnt) * AW'(LINE_BYTES) + AW'(hcnt[XW-1:1]);

  // stage 1: plane bytes arrive, index is formed
  logic          v1, odd1;
  logic [XW-1:0] x1;
  logic [YW-1:0] y1;
  logic [7:0]    hold, idx1;

  assign idx1 = odd1 ? hold : {plane_b_q[7:4], plane_a_q[7:4]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1   <= 1'b0;
      odd1 <= 1'b0;
      x1   <= '0;
      y1   <= '0;
      hold <= '0;
    end else begin
      v1   <= vis0;
      odd1 <= hcnt[0];
      x1   <= hcnt;
      y1   <= vcnt;
      if (v1 && !odd1) hold <= {plane_b_q[3:0], plane_a_q[3:0]};
    end
  end

  // palette: upper byte keeps only the 7 colour bits
  logic [6:0] pal_hi [256];
  logic [7:0] pal_lo [256];
  logic       pal_hit;

  assign pal_hit = pal_we && (pal_addr >= PAL_FIRST) && (pal_addr <= PAL_LAST);

  always_ff @(posedge clk) begin
    if (pal_hit) begin
      if (pal_addr[0]) pal_lo[pal_addr[8:1]] <= pal_wdata;
      else             pal_hi[pal_addr[8:1]] <= pal_wdata[6:0];
    end
  end

  // stage 2: palette word registered, output formed
  logic          v2;
  logic [XW-1:0] x2;
  logic [YW-1:0] y2;
  logic [14:0]   word2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v2    <= 1'b0;
      x2    <= '0;
      y2    <= '0;
      word2 <= '0;
    end else begin
      v2 <= v1;
      x2 <= x1;
      y2 <= y1;
      if (v1) word2 <= {pal_hi[idx1], pal_lo[idx1]};
    end
  end

  assign out_valid = v2;
  assign out_x     = x2;
  assign out_y     = y2;
  assign rgb       = v2 ? {word2[14:10], 3'b000, word2[9:5], 3'b000, word2[4:0], 3'b000}
                        : 24'h0;

endmodule

// File: rtl/scanout_checks.sv
module scanout_checks #(
  parameter int H_VIS = 384,
  parameter int V_VIS = 288,
  parameter int AW    = 16,
  parameter int XW    = 9,
  parameter int YW    = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fb_rd,
  input logic [AW-1:0] fb_addr,
  input logic          out_valid,
  input logic [XW-1:0] out_x,
  input logic [YW-1:0] out_y,
  input logic [23:0]   rgb
);

  p_black_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> rgb == 24'h0);

  p_valid_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_x < XW'(H_VIS)) && (out_y < YW'(V_VIS)));

  p_fetch_lead_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fb_rd |-> ##2 (out_valid && !out_x[0]));

  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_rd && $past(fb_rd, 2)) |-> fb_addr == AW'($past(fb_addr, 2) + 1'b1));

  p_column_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> out_x == XW'($past(out_x) + 1'b1));

endmodule

bind dual_plane_scanout scanout_checks #(
  .H_VIS(H_VIS), .V_VIS(V_VIS), .AW(AW), .XW(XW), .YW(YW)
) u_checks (
  .clk(clk), .rst_n(rst_n), .fb_rd(fb_rd), .fb_addr(fb_addr),
  .out_valid(out_valid), .out_x(out_x), .out_y(out_y), .rgb(rgb)
);

// File: tb/test_dual_plane_scanout.sv
module test_dual_plane_scanout;
  localparam int CLK_PERIOD = 10;
  localparam int HV = 16, HT = 24, VV = 6, VT = 8;
  localparam int LB = HV / 2;
  localparam int FRAME = HT * VT;
  localparam int AW = 16;

  logic clk = 0, rst_n = 0;
  logic fb_rd;
  logic [AW-1:0] fb_addr;
  logic [7:0] qa = 0, qb = 0, junk = 0;
  logic pal_we = 0;
  logic [AW-1:0] pal_addr = 0;
  logic [7:0] pal_wdata = 0;
  logic out_valid;
  logic [4:0] out_x;
  logic [2:0] out_y;
  logic [23:0] rgb;

  logic [7:0] mema [256];
  logic [7:0] memb [256];
  logic [7:0] m_hi [256];
  logic [7:0] m_lo [256];

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_plane_scanout #(.H_VIS(HV), .V_VIS(VV), .H_TOTAL(HT), .V_TOTAL(VT), .AW(AW)) i_dual_plane_scanout (
    .clk(clk), .rst_n(rst_n), .fb_rd(fb_rd), .fb_addr(fb_addr),
    .plane_a_q(qa), .plane_b_q(qb), .pal_we(pal_we), .pal_addr(pal_addr),
    .pal_wdata(pal_wdata), .out_valid(out_valid), .out_x(out_x), .out_y(out_y), .rgb(rgb));

  // synchronous plane memories; junk appears whenever no read was issued (R5)
  always @(posedge clk) begin
    junk <= junk + 8'h3B;
    qa <= fb_rd ? mema[fb_addr[7:0]] : junk;
    qb <= fb_rd ? memb[fb_addr[7:0]] : ~junk;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [23:0] model_rgb(input int x, input int y);
    int n;
    logic [7:0] a, b, idx;
    logic [15:0] w;
    n = y * LB + x / 2;
    a = mema[n];
    b = memb[n];
    idx = (x % 2 == 0) ? {b[7:4], a[7:4]} : {b[3:0], a[3:0]};
    w = {m_hi[idx], m_lo[idx]};
    return {w[14:10], 3'b000, w[9:5], 3'b000, w[4:0], 3'b000};
  endfunction

  task automatic pal_write(input logic [15:0] addr, input logic [7:0] data);
    @(negedge clk);
    pal_we = 1; pal_addr = addr; pal_wdata = data;
    @(negedge clk);
    pal_we = 0;
    if (addr >= 16'hFE00 && addr <= 16'hFFDF) begin
      if (addr[0]) m_lo[addr[8:1]] = data;
      else         m_hi[addr[8:1]] = data;
    end
  endtask

  task automatic wait_start();
    do @(negedge clk); while (!(out_x == 0 && out_y == 0));
  endtask

  task automatic check_frame(input string tag);
    wait_start();
    wait_start();
    for (int c = 0; c < FRAME; c++) begin
      int ex, ey, sc, sx, sy;
      bit ev, erd;
      ex = c % HT; ey = c / HT;
      ev = (ex < HV) && (ey < VV);
      chk(out_x == ex && out_y == ey, "R1 position", {out_y, 8'h0, out_x}, {ey[7:0], 8'h0, ex[7:0]});
      chk(out_valid == ev, "R1 valid", out_valid, ev);
      if (ev) chk(rgb === model_rgb(ex, ey), tag, rgb, model_rgb(ex, ey));
      else    chk(rgb === 24'h0, "R9 blank black", rgb, 0);
      sc = (c + 2) % FRAME; sx = sc % HT; sy = sc / HT;
      erd = (sx < HV) && (sy < VV) && (sx % 2 == 0);
      chk(fb_rd == erd, "R3 fetch strobe", fb_rd, erd);
      if (erd) chk(fb_addr == sy * LB + sx / 2, "R3 fetch address", fb_addr, sy * LB + sx / 2);
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && rgb == 0, "R9 reset outputs", {out_valid, rgb}, 0);
    chk(fb_rd == 0, "R9 reset no fetch", fb_rd, 0);
    chk(out_x == 0 && out_y == 0, "R9 reset position", {out_y, out_x}, 0);
  endtask

  task automatic t_latency();
    rst_n = 1;
    #1;
    chk(fb_rd == 1 && fb_addr == 0, "R3 first fetch", {fb_rd, fb_addr}, {1'b1, 16'h0});
    @(negedge clk);
    chk(out_valid == 0, "R2 one edge after reset", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 1 && out_x == 0 && out_y == 0, "R2 two edges after reset", {out_valid, out_y, out_x}, {1'b1, 8'h0});
    @(negedge clk);
    chk(out_x == 1 && out_y == 0, "R1 next column", {out_y, out_x}, 1);
  endtask

  task automatic t_ramp();
    for (int i = 0; i < 256; i++) begin
      mema[i] = 8'(i * 37 + 11);
      memb[i] = {4'(i % 15), 4'((i + 7) % 15)};
    end
    for (int k = 0; k < 480; k++) pal_write(16'hFE00 + 16'(k), 8'((k * 29 + (k >> 3)) ^ 8'h96));
    check_frame("R4 R5 R8 ramp pixel");
  endtask

  task automatic t_checker();
    for (int i = 0; i < 256; i++) begin
      mema[i] = (i % 2) ? 8'hF0 : 8'h0F;
      memb[i] = (i % 2) ? 8'hE1 : 8'h1E;
    end
    check_frame("R4 R5 checker pixel");
  endtask

  task automatic t_range();
    for (int i = 0; i < 256; i++) begin mema[i] = 8'h01; memb[i] = 8'h00; end
    pal_write(16'hFC00, 8'hFF);
    pal_write(16'h7E03, 8'hFF);
    pal_write(16'hFDFE, 8'hFF);
    pal_write(16'hFFE0, 8'hFF);
    pal_write(16'hFFE3, 8'hFF);
    check_frame("R7 out-of-range write ignored");
  endtask

  task automatic t_bounds();
    for (int i = 0; i < 256; i++) begin mema[i] = 8'h0F; memb[i] = 8'h0E; end
    pal_write(16'hFE00, 8'h7C);
    pal_write(16'hFFDF, 8'hA5);
    check_frame("R6 window edges");
  endtask

  task automatic t_byte_order();
    for (int i = 0; i < 256; i++) begin mema[i] = 8'h50; memb[i] = 8'h00; end
    pal_write(16'hFE0A, 8'hD5);
    check_frame("R6 R8 high byte only");
    pal_write(16'hFE0B, 8'h3E);
    check_frame("R6 R8 low byte only");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL R2 watchdog expired act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_latency();
    t_ramp();
    t_checker();
    t_range();
    t_bounds();
    t_byte_order();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule